// File: doc/BRIEF.md
# SMRAM Control and Top-Segment Access Gate

This block holds the two configuration bytes that a host bridge uses to govern system-management RAM. It also filters ordinary memory traffic against a reserved segment at the top of DRAM. The first byte carries four controls: an open flag that exposes management RAM to normal code, a closed flag, a sticky lock, and a global enable. The second byte carries a segment-enable flag and a two-bit size code. Both bytes are read and written one byte at a time through a simple configuration port. A write is held by the register at the next clock edge. Read data follows the address combinationally.

From the size code the block derives two values and drives them as outputs: the segment size in bytes, and the segment base, which is the top of RAM minus the size. For every memory access it is shown, the block raises a block flag when four conditions all hold. The access does not come from management mode, the segment and global enables are both set, and the address lies in the segment. The memory side must then return all-ones for a read and drop a write.

Locking is one-way. Once the lock bit is set, the open flag is forced low and stays low. The enable and size fields freeze until the synchronous reset.

Top module: `smram_guard`

## Requirements
- R1: After reset both bytes read 0x00, the size code is 00 (1 MB segment), and unused bits and unmapped addresses read 0.
- R2: The control byte sits at CTRL_OFS (bit0 open, bit1 closed, bit2 lock, bit3 global enable). While unlocked, writing bit0 sets or clears open, and a read returns the written value from the cycle after the write. Writes to unmapped addresses change nothing.
- R3: A write that sets bit2 (lock) clears open in that same write. While locked, writes that set open leave it at 0.
- R4: Lock stays set through any write and is cleared only by reset. After reset, open is writable again.
- R5: While unlocked, a write with both bit0 and bit1 set keeps open at its previous value and writes closed.
- R6: While locked, global enable, segment enable and the size code ignore writes. Closed remains writable. The write that sets lock still updates these fields.
- R7: The extended byte sits at EXT_OFS (bit0 segment enable, bits 2:1 size code). Codes 00, 01 and 10 give 1, 2 and 8 MB. Code 11 gives EXT_MB megabytes. seg_size_o is the size in bytes.
- R8: seg_base_o equals RAM_MB megabytes minus seg_size_o.
- R9: acc_block_o is 1 exactly when acc_valid_i is 1, acc_smm_i is 0, segment enable and global enable are both 1, and seg_base_o <= acc_addr_i < RAM top. The byte just below the base is never blocked.
- R10: An access with acc_smm_i = 1 is never blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | CFG_AW | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_addr_i |
| acc_valid_i | input | 1 | Memory access present |
| acc_smm_i | input | 1 | Access issued in management mode |
| acc_addr_i | input | AW | Memory access byte address |
| acc_block_o | output | 1 | Access hits the protected segment and must be gated |
| seg_base_o | output | AW | First byte address of the protected segment |
| seg_size_o | output | AW | Protected segment size in bytes |

## Verification
Read data, segment geometry and the block flag are combinational: a register write is captured at the first rising edge after the strobe and shows on these outputs throughout the next cycle. The bench drives each step one nanosecond after a rising edge and queues the expected value, and a monitor compares it at the following falling edge. Every check of a write therefore falls one full cycle after that write, while access and geometry checks compare in the cycle they are driven.

// File: rtl/smg_pkg.sv
// Shared field layouts for the management-RAM control bytes.
// Assumes packed bit order matches the configuration byte layout.
package smg_pkg;

    localparam int MB_SHIFT = 20;

    // Control byte: bit3 global enable, bit2 lock, bit1 closed, bit0 open
    typedef struct packed {
        logic g_en;
        logic lock;
        logic closed;
        logic open;
    } smg_ctrl_t;

    typedef enum logic [1:0] {
        SZ_1M  = 2'b00,
        SZ_2M  = 2'b01,
        SZ_8M  = 2'b10,
        SZ_EXT = 2'b11
    } smg_size_e;

    // Extended byte: bits 2:1 size code, bit0 segment enable
    typedef struct packed {
        smg_size_e size;
        logic      seg_en;
    } smg_ext_t;

endpackage

// File: rtl/smg_ctrl_reg.sv
// Control byte with open, closed, lock and global-enable fields.
// Assumes one byte write per cycle; lock is sticky until synchronous reset.
module smg_ctrl_reg
    import smg_pkg::*;
#(
    parameter int          CFG_AW   = 8,
    parameter int unsigned CTRL_OFS = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [3:0]        cfg_wdata_i,
    output smg_ctrl_t         ctrl_o
);

    smg_ctrl_t ctrl_q;
    smg_ctrl_t wr_f;
    logic      wr_hit;
    logic      both_oc;

    assign wr_hit  = cfg_wr_i && (cfg_addr_i == CFG_AW'(CTRL_OFS));
    assign wr_f    = smg_ctrl_t'(cfg_wdata_i);
    assign both_oc = wr_f.open && wr_f.closed;

    // Update fields on a hit, honouring lock and the open/closed conflict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hit) begin
            ctrl_q.lock   <= ctrl_q.lock | wr_f.lock;
            ctrl_q.closed <= wr_f.closed;
            if (!ctrl_q.lock) begin
                ctrl_q.g_en <= wr_f.g_en;
            end
            if (ctrl_q.lock || wr_f.lock) begin
                ctrl_q.open <= 1'b0;
            end else if (!both_oc) begin
                ctrl_q.open <= wr_f.open;
            end
        end
    end

    assign ctrl_o = ctrl_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> ctrl_q.lock); // R4
    AST_OPEN_LOW_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |-> !ctrl_q.open); // R3
    AST_GEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> $stable(ctrl_q.g_en)); // R6
    AST_CONFLICT_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !ctrl_q.lock && !wr_f.lock && cfg_wdata_i[0] && cfg_wdata_i[1])
        |=> $stable(ctrl_q.open)); // R5

endmodule

// File: rtl/smg_ext_reg.sv
// Extended byte holding segment enable and size code.
// Assumes lock_i comes from the control byte; writes are dropped while it is set.
module smg_ext_reg
    import smg_pkg::*;
#(
    parameter int          CFG_AW  = 8,
    parameter int unsigned EXT_OFS = 'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [2:0]        cfg_wdata_i,
    input  logic              lock_i,
    output smg_ext_t          ext_o
);

    smg_ext_t ext_q;
    logic     wr_hit;

    assign wr_hit = cfg_wr_i && (cfg_addr_i == CFG_AW'(EXT_OFS));

    // Capture enable and size on an unlocked hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (wr_hit && !lock_i) begin
            ext_q <= smg_ext_t'(cfg_wdata_i);
        end
    end

    assign ext_o = ext_q;

    AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(ext_q)); // R6

endmodule

// File: rtl/smg_seg_decode.sv
// Turns the size code into segment size and base at the top of RAM.
// Assumes RAM_MB megabytes fit in AW bits and every size is below RAM_MB.
module smg_seg_decode
    import smg_pkg::*;
#(
    parameter int AW     = 32,
    parameter int RAM_MB = 128,
    parameter int EXT_MB = 16
) (
    input  smg_size_e         size_i,
    output logic [AW-1:0]     ram_top_o,
    output logic [AW-1:0]     base_o,
    output logic [AW-1:0]     size_o
);

    localparam int            NCODES  = 4;
    localparam logic [AW-1:0] RAM_TOP = AW'(RAM_MB) << MB_SHIFT;

    logic [AW-1:0] size_lut [NCODES];

    // One table entry per size code; the all-ones code takes the extended size
    for (genvar c = 0; c < NCODES; c++) begin : g_lut
        localparam int SEG_MB = (c == 0) ? 1 :
                                (c == 1) ? 2 :
                                (c == 2) ? 8 : EXT_MB;
        assign size_lut[c] = AW'(SEG_MB) << MB_SHIFT;
    end

    assign ram_top_o = RAM_TOP;
    assign size_o    = size_lut[size_i];
    assign base_o    = RAM_TOP - size_o;

endmodule

// File: rtl/smg_filter.sv
// Flags non-management accesses that land inside the enabled segment.
// Assumes base and top come from the decoder; purely combinational.
module smg_filter #(
    parameter int AW = 32
) (
    input  logic          valid_i,
    input  logic          smm_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] top_i,
    input  logic          seg_en_i,
    input  logic          g_en_i,
    output logic          block_o
);

    logic in_seg;

    assign in_seg  = (addr_i >= base_i) && (addr_i < top_i);
    assign block_o = valid_i && !smm_i && seg_en_i && g_en_i && in_seg;

endmodule

// File: rtl/smram_guard.sv
// Top: control and extended bytes, segment decoder and access filter.
// Assumes a single byte-wide configuration port and one access per cycle.
module smram_guard
    import smg_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          CFG_AW   = 8,
    parameter int unsigned CTRL_OFS = 'h40,
    parameter int unsigned EXT_OFS  = 'h41,
    parameter int          RAM_MB   = 128,
    parameter int          EXT_MB   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [7:0]        cfg_wdata_i,
    output logic [7:0]        cfg_rdata_o,
    input  logic              acc_valid_i,
    input  logic              acc_smm_i,
    input  logic [AW-1:0]     acc_addr_i,
    output logic              acc_block_o,
    output logic [AW-1:0]     seg_base_o,
    output logic [AW-1:0]     seg_size_o
);

    smg_ctrl_t     ctrl;
    smg_ext_t      ext;
    logic [AW-1:0] ram_top;
    logic          unused_wdata;

    assign unused_wdata = ^cfg_wdata_i[7:4];

    smg_ctrl_reg #(.CFG_AW(CFG_AW), .CTRL_OFS(CTRL_OFS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i[3:0]), .ctrl_o(ctrl)
    );

    smg_ext_reg #(.CFG_AW(CFG_AW), .EXT_OFS(EXT_OFS)) u_ext (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i[2:0]), .lock_i(ctrl.lock), .ext_o(ext)
    );

    smg_seg_decode #(.AW(AW), .RAM_MB(RAM_MB), .EXT_MB(EXT_MB)) u_dec (
        .size_i(ext.size), .ram_top_o(ram_top), .base_o(seg_base_o), .size_o(seg_size_o)
    );

    smg_filter #(.AW(AW)) u_flt (
        .valid_i(acc_valid_i), .smm_i(acc_smm_i), .addr_i(acc_addr_i),
        .base_i(seg_base_o), .top_i(ram_top), .seg_en_i(ext.seg_en),
        .g_en_i(ctrl.g_en), .block_o(acc_block_o)
    );

    // Read mux: mapped bytes zero-extended, everything else reads zero
    always_comb begin
        cfg_rdata_o = 8'h00;
        if (cfg_addr_i == CFG_AW'(CTRL_OFS)) begin
            cfg_rdata_o = {4'h0, ctrl};
        end else if (cfg_addr_i == CFG_AW'(EXT_OFS)) begin
            cfg_rdata_o = {5'h00, ext};
        end
    end

    AST_SMM_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_smm_i) |-> !acc_block_o); // R10
    AST_BLOCK_INSIDE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        acc_block_o |-> (acc_addr_i >= seg_base_o)); // R9
    AST_BASE_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        seg_base_o < (AW'(RAM_MB) << MB_SHIFT)); // R8

endmodule

// File: tb/smram_guard_bench.sv
`timescale 1ns/1ps
module smram_guard_bench;

    localparam int AW   = 32;
    localparam int CTRL = 'h40;
    localparam int EXT  = 'h41;
    localparam logic [31:0] MB = 32'h0010_0000;
    localparam logic [31:0] TOP = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_smm = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_block;
    logic [31:0] seg_base;
    logic [31:0] seg_size;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    smram_guard #(.AW(AW), .CTRL_OFS(CTRL), .EXT_OFS(EXT)) u_smram_guard (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .acc_valid_i(acc_valid),
        .acc_smm_i(acc_smm), .acc_addr_i(acc_addr), .acc_block_o(acc_block),
        .seg_base_o(seg_base), .seg_size_o(seg_size)
    );

    // Monitor: pop queued expectations and compare mid-cycle
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                0:       act = {24'h0, cfg_rdata};
                1:       act = {31'h0, acc_block};
                2:       act = seg_base;
                default: act = seg_size;
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
        acc_valid = 1'b0;
        acc_smm = 1'b0;
    endtask

    task automatic cfg_write(input int a, input logic [7:0] d);
        step();
        cfg_wr = 1'b1;
        cfg_addr = 8'(a);
        cfg_wdata = d;
    endtask

    task automatic chk_rd(input int a, input logic [7:0] e, input string tag);
        step();
        cfg_addr = 8'(a);
        q.push_back('{0, {24'h0, e}, tag});
    endtask

    task automatic chk_acc(input logic [31:0] a, input logic smm, input logic e, input string tag);
        step();
        acc_valid = 1'b1;
        acc_smm = smm;
        acc_addr = a;
        q.push_back('{1, {31'h0, e}, tag});
    endtask

    task automatic chk_geom(input int mb, input string tag);
        step();
        q.push_back('{2, TOP - MB * mb, tag});
        q.push_back('{3, MB * mb, tag});
    endtask

    task automatic do_reset();
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Driver: stimulus plus expected results
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        chk_rd(CTRL, 8'h00, "R1 ctrl reset");
        chk_rd(EXT, 8'h00, "R1 ext reset");
        chk_rd('h00, 8'h00, "R1 unmapped reads zero");
        chk_geom(1, "R1 R7 R8 reset size 1MB");
        chk_acc(TOP - MB, 1'b0, 1'b0, "R9 disabled segment passes");

        cfg_write(CTRL, 8'h01);
        chk_rd(CTRL, 8'h01, "R2 open set");
        cfg_write(CTRL, 8'h00);
        chk_rd(CTRL, 8'h00, "R2 open clear");
        cfg_write(CTRL, 8'h01);
        cfg_write('h42, 8'hFF);
        chk_rd(CTRL, 8'h01, "R2 unmapped write ignored");

        cfg_write(CTRL, 8'h03);
        chk_rd(CTRL, 8'h03, "R5 conflict keeps open 1");
        cfg_write(CTRL, 8'h00);
        cfg_write(CTRL, 8'h03);
        chk_rd(CTRL, 8'h02, "R5 conflict keeps open 0");

        cfg_write(EXT, 8'h01);
        chk_geom(1, "R7 R8 code 00");
        cfg_write(EXT, 8'h03);
        chk_geom(2, "R7 R8 code 01");
        cfg_write(EXT, 8'h05);
        chk_geom(8, "R7 R8 code 10");
        cfg_write(EXT, 8'hFF);
        chk_rd(EXT, 8'h07, "R1 R7 ext unused bits read zero");
        chk_geom(16, "R7 R8 code 11 extended");

        cfg_write(CTRL, 8'h0A);
        chk_rd(CTRL, 8'h0A, "R2 enable and closed");
        chk_acc(TOP - 16 * MB - 1, 1'b0, 1'b0, "R9 byte below base");
        chk_acc(TOP - 16 * MB, 1'b0, 1'b1, "R9 first segment byte");
        chk_acc(TOP - 1, 1'b0, 1'b1, "R9 last segment byte");
        chk_acc(TOP, 1'b0, 1'b0, "R9 above RAM top");
        chk_acc(TOP - 16 * MB, 1'b1, 1'b0, "R10 management access passes");

        cfg_write(EXT, 8'h05);
        chk_acc(TOP - 16 * MB, 1'b0, 1'b0, "R9 old base outside 8MB");
        chk_acc(TOP - 8 * MB - 1, 1'b0, 1'b0, "R9 below 8MB base");
        chk_acc(TOP - 8 * MB, 1'b0, 1'b1, "R9 8MB base blocked");

        cfg_write(CTRL, 8'h09);
        chk_rd(CTRL, 8'h09, "R2 open with enable");
        cfg_write(CTRL, 8'h0D);
        chk_rd(CTRL, 8'h0C, "R3 lock clears open");
        cfg_write(CTRL, 8'h0D);
        chk_rd(CTRL, 8'h0C, "R3 open ignored while locked");
        cfg_write(CTRL, 8'h0F);
        chk_rd(CTRL, 8'h0E, "R6 closed writable while locked");
        cfg_write(CTRL, 8'h04);
        chk_rd(CTRL, 8'h0C, "R6 global enable frozen");
        cfg_write(CTRL, 8'h00);
        chk_rd(CTRL, 8'h0C, "R4 lock sticky");
        cfg_write(EXT, 8'h00);
        chk_rd(EXT, 8'h05, "R6 ext frozen");
        chk_geom(8, "R6 size frozen");
        chk_acc(TOP - 8 * MB, 1'b0, 1'b1, "R9 locked segment blocked");
        chk_acc(TOP - 8 * MB, 1'b1, 1'b0, "R10 locked management passes");

        do_reset();
        chk_rd(CTRL, 8'h00, "R4 reset clears lock");
        chk_rd(EXT, 8'h00, "R4 reset clears ext");
        cfg_write(CTRL, 8'h01);
        chk_rd(CTRL, 8'h01, "R4 open writable after reset");
        cfg_write(EXT, 8'h02);
        cfg_write(CTRL, 8'h08);
        chk_acc(TOP - 2 * MB, 1'b0, 1'b0, "R9 segment enable off");
        cfg_write(EXT, 8'h03);
        cfg_write(CTRL, 8'h00);
        chk_acc(TOP - 2 * MB, 1'b0, 1'b0, "R9 global enable off");
        cfg_write(CTRL, 8'h08);
        chk_acc(TOP - 2 * MB, 1'b0, 1'b1, "R9 both enables on");
        chk_acc(TOP - 2 * MB - 1, 1'b0, 1'b0, "R9 below 2MB base");

        step();
        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule